// File: doc/BRIEF.md
# Two-Phase Multicast Tree Router Node

This block is one node of a tree-shaped on-chip network. The network carries variable-length packets one word at a time, in wormhole fashion. The node has one link toward its parent, `NCH` links toward its children and one link to the local endpoint. Each link has a valid/ready pair in each direction. Every packet travels in two phases. First it climbs toward a chosen ancestor, which becomes the subtree root. It then descends from that root and is copied onto every branch below it. Once descending, a packet never climbs again. Only the descending phase may fork a packet.

The header word carries three fields: a direction bit, a count of remaining upward hops, and a child mask. The child mask is used only at the node where the packet turns. No route table is consulted along the way, and the header holds no list of destinations. Each node's local endpoint is gated by the `accept_en` input. A descending packet that is not accepted is absorbed without stalling the broadcast.

There are two forwarding paths. The upward path goes to the parent. The downward path is a group made of all child outputs plus the local output. Each path is claimed by one input for a whole packet and is released after that packet's last word. A round-robin arbiter chooses among competing packet heads, and it does so only while the path is free.

Top module: `tree_router_node`

## Requirements
- R1: A header arriving on a child or local input with direction bit DW-1 = 0 and hop field [DW-2 -: HW] nonzero leaves only on the parent output. Its hop field is reduced by one and every other bit is unchanged.
- R2: A header arriving on a child or local input with hop field zero turns at this node. It is sent to each child c whose bit c of header field [NCH-1:0] is set, and to the local output as R4 allows. It leaves with bit DW-1 set to 1 and all other bits unchanged.
- R3: A packet arriving on the parent input is copied unchanged to every child output, and to the local output as R4 allows.
- R4: `accept_en` is sampled when the downward path is granted to a packet. If it is 1, the whole packet appears on the local output. If it is 0, nothing appears there and the broadcast does not wait on `loc_out_ready`.
- R5: A downward word moves on all of its selected outputs in the same cycle. While any selected output holds ready low, no copy of that word transfers.
- R6: Once a path is claimed, the remaining words of that packet follow in order on the same outputs, and no other input's words are interleaved. The path is released after the word whose flit bit DW (last flag) is 1 has transferred.
- R7: Heads waiting for the same free path are served round-robin. Input indices are children 0..NCH-1, local NCH and parent NCH+1. After input k is granted, the search starts at k+1.
- R8: Every word of every packet reaches each of its destinations exactly once, whatever the packet length, and no port outside the destination set receives it.
- R9: While reset is held, every output valid and every input ready is 0.
- R10: A header presented to a free path becomes visible at the outputs after one clock edge. From then on, words pass from input to output within the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| accept_en | input | 1 | Local endpoint keeps descending packets when 1 |
| par_in_valid | input | 1 | Word from parent is valid |
| par_in_ready | output | 1 | Node takes the parent word |
| par_in_flit | input | DW+1 | Parent word, bit DW is the last flag |
| par_out_valid | output | 1 | Word toward parent is valid |
| par_out_ready | input | 1 | Parent takes the word |
| par_out_flit | output | DW+1 | Word toward parent |
| chd_in_valid | input | NCH | Per-child input valid |
| chd_in_ready | output | NCH | Per-child input ready |
| chd_in_flit | input | NCH*(DW+1) | Child words, child c in slice c |
| chd_out_valid | output | NCH | Per-child output valid |
| chd_out_ready | input | NCH | Per-child output ready |
| chd_out_flit | output | NCH*(DW+1) | Words toward children, child c in slice c |
| loc_in_valid | input | 1 | Local injection valid |
| loc_in_ready | output | 1 | Local injection ready |
| loc_in_flit | input | DW+1 | Local injected word |
| loc_out_valid | output | 1 | Local delivery valid |
| loc_out_ready | input | 1 | Local endpoint takes the word |
| loc_out_flit | output | DW+1 | Local delivered word |

## Verification
A header is granted on the edge after it is offered to a free path. It is therefore due at the outputs one cycle later, and every following word passes through in the cycle in which both sides handshake. The bench drives inputs just after the falling edge and samples every handshake a moment later in the same half-cycle. Each recorded transfer is thus the one the next rising edge commits. The grant delay is probed directly by sampling the parent output in the cycle of the offer and in the cycle after it. The lockstep rule is probed by holding one child's ready low for several cycles and confirming that no downward copy moves.

// File: rtl/trn_pkg.sv
package trn_pkg;
    typedef enum logic {PATH_UP = 1'b0, PATH_DN = 1'b1} path_e;
endpackage

// File: rtl/trn_rr_arb.sv
module trn_rr_arb #(
    parameter int N = 6,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic [IW-1:0] gnt_idx
);
    typedef struct packed { logic [IW-1:0] ptr; } arb_st_t;
    arb_st_t st_q, st_d;

    always_comb begin
        logic found;
        int   idx;
        st_d    = st_q;
        gnt_idx = '0;
        found   = 1'b0;
        for (int off = 0; off < N; off++) begin
            idx = int'(st_q.ptr) + off;
            if (idx >= N) idx -= N;
            if (!found && req[idx]) begin
                found   = 1'b1;
                gnt_idx = IW'(idx);
            end
        end
        if (adv && found)
            st_d.ptr = (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    adv_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> (|req));
endmodule

// File: rtl/trn_path_lock.sv
module trn_path_lock #(
    parameter int NIN = 6,
    parameter int TW  = 1,
    localparam int IW = (NIN > 1) ? $clog2(NIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIN-1:0]    req,
    input  logic [NIN*TW-1:0] tag_in,
    input  logic              xfer,
    input  logic              last,
    output logic              busy,
    output logic [IW-1:0]     owner,
    output logic              first,
    output logic [TW-1:0]     tag
);
    typedef struct packed {
        logic          busy;
        logic [IW-1:0] owner;
        logic          first;
        logic [TW-1:0] tag;
    } lock_st_t;
    lock_st_t st_q, st_d;
    logic [IW-1:0] gidx;
    logic          adv;

    assign adv = !st_q.busy && (|req);

    trn_rr_arb #(.N(NIN)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req), .adv(adv), .gnt_idx(gidx)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (|req) begin
                st_d.busy  = 1'b1;
                st_d.owner = gidx;
                st_d.first = 1'b1;
                st_d.tag   = tag_in[int'(gidx)*TW +: TW];
            end
        end else if (xfer) begin
            st_d.first = 1'b0;
            if (last) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign owner = st_q.owner;
    assign first = st_q.first;
    assign tag   = st_q.tag;

    // R6
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !(xfer && last)) |=> (st_q.busy && $stable(st_q.owner)));
endmodule

// File: rtl/tree_router_node.sv
module tree_router_node
    import trn_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16,
    parameter int HW  = 4,
    localparam int FW  = DW + 1,
    localparam int NIN = NCH + 2,
    localparam int IW  = $clog2(NIN),
    localparam int LOC = NCH,
    localparam int PAR = NCH + 1,
    localparam int DTW = NCH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_en,
    input  logic              par_in_valid,
    output logic              par_in_ready,
    input  logic [FW-1:0]     par_in_flit,
    output logic              par_out_valid,
    input  logic              par_out_ready,
    output logic [FW-1:0]     par_out_flit,
    input  logic [NCH-1:0]    chd_in_valid,
    output logic [NCH-1:0]    chd_in_ready,
    input  logic [NCH*FW-1:0] chd_in_flit,
    output logic [NCH-1:0]    chd_out_valid,
    input  logic [NCH-1:0]    chd_out_ready,
    output logic [NCH*FW-1:0] chd_out_flit,
    input  logic              loc_in_valid,
    output logic              loc_in_ready,
    input  logic [FW-1:0]     loc_in_flit,
    output logic              loc_out_valid,
    input  logic              loc_out_ready,
    output logic [FW-1:0]     loc_out_flit
);
    typedef struct packed { logic [NIN-1:0] sop; } node_st_t;
    node_st_t st_q, st_d;

    logic [NIN-1:0]         in_valid, in_ready;
    logic [NIN-1:0][FW-1:0] in_flit;
    path_e                  route [NIN];
    logic [NIN-1:0]         req_up, req_dn;
    logic [NIN*HW-1:0]      up_tag_in;
    logic [NIN*DTW-1:0]     dn_tag_in;

    logic          up_busy, up_first, up_xfer;
    logic [IW-1:0] up_owner;
    logic [HW-1:0] up_tag;
    logic [FW-1:0] up_word;
    logic          dn_busy, dn_first, dn_xfer, dn_base, dn_all;
    logic [IW-1:0] dn_owner;
    logic [DTW-1:0] dn_tag, rdy_v;
    logic [NCH-1:0] dn_sel;
    logic           dn_lsel;
    logic [FW-1:0]  dn_word, dn_flit;

    for (genvar c = 0; c < NCH; c++) begin : g_chd
        assign in_valid[c]            = chd_in_valid[c];
        assign in_flit[c]             = chd_in_flit[c*FW +: FW];
        assign chd_in_ready[c]        = in_ready[c];
        assign chd_out_flit[c*FW +: FW] = dn_flit;
        assign chd_out_valid[c]       = dn_base && dn_sel[c] && (&(rdy_v | (DTW'(1) << c)));
    end
    assign in_valid[LOC] = loc_in_valid;
    assign in_flit[LOC]  = loc_in_flit;
    assign loc_in_ready  = in_ready[LOC];
    assign in_valid[PAR] = par_in_valid;
    assign in_flit[PAR]  = par_in_flit;
    assign par_in_ready  = in_ready[PAR];

    // header decode per input: direction, hop count and root mask
    always_comb begin
        logic          phase;
        logic [HW-1:0] hop;
        for (int i = 0; i < NIN; i++) begin
            phase = in_flit[i][DW-1];
            hop   = in_flit[i][DW-2 -: HW];
            route[i] = (i != PAR && !phase && hop != '0) ? PATH_UP : PATH_DN;
            req_up[i] = in_valid[i] && st_q.sop[i] && (route[i] == PATH_UP);
            req_dn[i] = in_valid[i] && st_q.sop[i] && (route[i] == PATH_DN);
            up_tag_in[i*HW +: HW] = hop;
            dn_tag_in[i*DTW +: DTW] = {accept_en,
                (i == PAR || phase) ? {NCH{1'b1}} : in_flit[i][NCH-1:0]};
        end
    end

    trn_path_lock #(.NIN(NIN), .TW(HW)) u_up_lock (
        .clk(clk), .rst_n(rst_n), .req(req_up), .tag_in(up_tag_in),
        .xfer(up_xfer), .last(up_word[DW]),
        .busy(up_busy), .owner(up_owner), .first(up_first), .tag(up_tag)
    );

    trn_path_lock #(.NIN(NIN), .TW(DTW)) u_dn_lock (
        .clk(clk), .rst_n(rst_n), .req(req_dn), .tag_in(dn_tag_in),
        .xfer(dn_xfer), .last(dn_word[DW]),
        .busy(dn_busy), .owner(dn_owner), .first(dn_first), .tag(dn_tag)
    );

    // upward path: single output, hop count decremented on the header
    always_comb begin
        up_word       = in_flit[up_owner];
        par_out_valid = up_busy && in_valid[up_owner];
        par_out_flit  = up_word;
        if (up_first) par_out_flit[DW-2 -: HW] = up_word[DW-2 -: HW] - 1'b1;
        up_xfer = par_out_valid && par_out_ready;
    end

    // downward path: lockstep copy to the selected children and local port
    always_comb begin
        dn_word = in_flit[dn_owner];
        dn_flit = dn_word;
        if (dn_first) dn_flit[DW-1] = 1'b1;
        dn_sel  = dn_tag[NCH-1:0];
        dn_lsel = dn_tag[NCH];
        dn_base = dn_busy && in_valid[dn_owner];
        rdy_v   = {loc_out_ready, chd_out_ready} | ~{dn_lsel, dn_sel};
        dn_all  = &rdy_v;
        dn_xfer = dn_base && dn_all;
    end
    assign loc_out_flit  = dn_flit;
    assign loc_out_valid = dn_base && dn_lsel && (&(rdy_v | (DTW'(1) << NCH)));

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NIN; i++) begin
            in_ready[i] = (up_busy && up_owner == IW'(i) && par_out_ready) ||
                          (dn_busy && dn_owner == IW'(i) && dn_all);
            if (in_valid[i] && in_ready[i]) st_d.sop[i] = in_flit[i][DW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sop: '1};
        else        st_q <= st_d;
    end

    // R1
    up_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_out_valid |-> (up_owner != IW'(PAR)));
    // R1
    hop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_out_valid && up_first) |-> (par_out_flit[DW-2 -: HW] == up_tag - 1'b1));
    // R3
    par_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_busy && dn_owner == IW'(PAR)) |-> (dn_sel == {NCH{1'b1}}));
    // R5
    lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(chd_out_valid & chd_out_ready)) |-> ((chd_out_valid & chd_out_ready) == dn_sel));
endmodule

// File: tb/tree_router_node_tb.sv
module tree_router_node_tb;
    localparam int NCH = 4, DW = 16, HW = 4, FW = DW + 1, NP = NCH + 2;

    logic clk = 1'b0, rst_n = 1'b0, accept_en = 1'b0;
    always #5 clk = ~clk;

    logic par_in_valid, par_in_ready, par_out_valid, par_out_ready;
    logic [FW-1:0] par_in_flit, par_out_flit, loc_in_flit, loc_out_flit;
    logic [NCH-1:0] chd_in_valid, chd_in_ready, chd_out_valid, chd_out_ready;
    logic [NCH*FW-1:0] chd_in_flit, chd_out_flit;
    logic loc_in_valid, loc_in_ready, loc_out_valid, loc_out_ready;

    tree_router_node #(.NCH(NCH), .DW(DW), .HW(HW)) u_dut (
        .clk(clk), .rst_n(rst_n), .accept_en(accept_en),
        .par_in_valid(par_in_valid), .par_in_ready(par_in_ready), .par_in_flit(par_in_flit),
        .par_out_valid(par_out_valid), .par_out_ready(par_out_ready), .par_out_flit(par_out_flit),
        .chd_in_valid(chd_in_valid), .chd_in_ready(chd_in_ready), .chd_in_flit(chd_in_flit),
        .chd_out_valid(chd_out_valid), .chd_out_ready(chd_out_ready), .chd_out_flit(chd_out_flit),
        .loc_in_valid(loc_in_valid), .loc_in_ready(loc_in_ready), .loc_in_flit(loc_in_flit),
        .loc_out_valid(loc_out_valid), .loc_out_ready(loc_out_ready), .loc_out_flit(loc_out_flit)
    );

    // port index: children 0..3, local 4, parent 5
    logic [FW-1:0] srcq [NP][$];
    logic [NP-1:0] sv = '0, acc_pend = '0, ordy = '0, rdy_ovr = '1;
    logic [FW-1:0] sf [NP];
    logic [NP-1:0] sr, ov;
    logic [FW-1:0] of_ [NP];
    bit rnd = 1'b0;

    assign chd_in_valid  = sv[3:0];
    assign chd_in_flit   = {sf[3], sf[2], sf[1], sf[0]};
    assign loc_in_valid  = sv[4];
    assign loc_in_flit   = sf[4];
    assign par_in_valid  = sv[5];
    assign par_in_flit   = sf[5];
    assign sr            = {par_in_ready, loc_in_ready, chd_in_ready};
    assign ov            = {par_out_valid, loc_out_valid, chd_out_valid};
    assign chd_out_ready = ordy[3:0];
    assign loc_out_ready = ordy[4];
    assign par_out_ready = ordy[5];
    always_comb begin
        for (int c = 0; c < NCH; c++) of_[c] = chd_out_flit[c*FW +: FW];
        of_[4] = loc_out_flit;
        of_[5] = par_out_flit;
    end

    int n_chk = 0, n_bad = 0;
    logic [5:0]  exp_dest [128];
    logic [5:0]  got [128];
    logic [15:0] exp_hdr [128];
    int          exp_len [128];
    string       exp_tag [128];
    int cur_id [NP], cur_seq [NP];
    bit in_pkt [NP];
    int dn_cnt = 0;
    int ord [8];
    int nord = 0;

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // expected destinations and header from the routing rules
    task automatic send(int src, int id, int hop, logic [3:0] mask, int len);
        logic [15:0] h;
        if (src == 5) h = {1'b1, 4'd0, 7'(id), mask};
        else          h = {1'b0, 4'(hop), 7'(id), mask};
        srcq[src].push_back({len == 1, h});
        for (int s = 1; s < len; s++) srcq[src].push_back({s == len - 1, 7'(id), 9'(s)});
        exp_len[id] = len;
        got[id] = '0;
        if (src == 5) begin
            exp_dest[id] = {1'b0, accept_en, 4'hF}; exp_hdr[id] = h; exp_tag[id] = "R3";
        end else if (hop != 0) begin
            exp_dest[id] = 6'b100000; exp_hdr[id] = {1'b0, 4'(hop - 1), 7'(id), mask}; exp_tag[id] = "R1";
        end else begin
            exp_dest[id] = {1'b0, accept_en, mask}; exp_hdr[id] = h | 16'h8000; exp_tag[id] = "R2";
        end
    endtask

    task automatic take(int o, logic [FW-1:0] f);
        int id;
        if (!in_pkt[o]) begin
            id = int'(f[10:4]);
            cur_id[o] = id; cur_seq[o] = 1; in_pkt[o] = 1'b1;
            chk(exp_dest[id][o] && !got[id][o], "R8", {got[id], 2'b0, 6'(o)}, {exp_dest[id], 8'h0});
            chk(f == {exp_len[id] == 1, exp_hdr[id]}, (o == 4) ? "R4" : exp_tag[id], f,
                {exp_len[id] == 1, exp_hdr[id]});
            if (o == 5 && nord < 8) begin ord[nord] = id; nord++; end
        end else begin
            id = cur_id[o];
            chk(f == {cur_seq[o] == exp_len[id] - 1, 7'(id), 9'(cur_seq[o])}, "R6", f,
                {cur_seq[o] == exp_len[id] - 1, 7'(id), 9'(cur_seq[o])});
            cur_seq[o]++;
        end
        if (f[FW-1]) begin in_pkt[o] = 1'b0; got[id][o] = 1'b1; end
    endtask

    task automatic obs();
        logic [5:0] dx;
        int k, id;
        dx = ov & ordy;
        if (|dx[4:0]) begin
            dn_cnt++;
            k = 0;
            while (!dx[k]) k++;
            id = in_pkt[k] ? cur_id[k] : int'(of_[k][10:4]);
            chk(dx[4:0] == exp_dest[id][4:0], "R5", dx, exp_dest[id]);
        end
        for (int o = 0; o < NP; o++) if (dx[o]) take(o, of_[o]);
        for (int p = 0; p < NP; p++)
            if (sv[p] && sr[p]) begin void'(srcq[p].pop_front()); acc_pend[p] = 1'b1; end
    endtask

    task automatic cycle();
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            if (acc_pend[p]) begin sv[p] = 1'b0; acc_pend[p] = 1'b0; end
            if (!sv[p] && srcq[p].size() > 0 && (!rnd || $urandom_range(3) != 0)) begin
                sv[p] = 1'b1; sf[p] = srcq[p][0];
            end
            ordy[p] = rnd ? ($urandom_range(3) != 0) : rdy_ovr[p];
        end
        #1;
        obs();
    endtask

    task automatic drain();
        int idle = 0;
        bit busy;
        while (idle < 20) begin
            cycle();
            busy = |sv;
            for (int p = 0; p < NP; p++) if (srcq[p].size() > 0) busy = 1'b1;
            idle = busy ? 0 : idle + 1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sv = '0; acc_pend = '0; ordy = '0;
        for (int p = 0; p < NP; p++) in_pkt[p] = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(ov == '0 && sr == '0, "R9", {ov, sr}, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rnd_phase(int npk, bit acc);
        accept_en = acc; rnd = 1'b1;
        if (acc) send(3, 100, 0, 4'b1010, 40);
        for (int id = 0; id < npk; id++)
            send($urandom_range(5), id, $urandom_range(2), 4'($urandom), $urandom_range(1, 10));
        drain();
        for (int id = 0; id < npk; id++) begin
            chk(got[id] == exp_dest[id], "R8", got[id], exp_dest[id]);
            if (!acc) chk(!got[id][4], "R4", got[id], exp_dest[id]);
        end
        if (acc) chk(got[100] == exp_dest[100], "R8", got[100], exp_dest[100]);
        rnd = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int p = 0; p < NP; p++) sf[p] = '0;
        // reset state and grant delay
        do_reset();
        rdy_ovr = '1; accept_en = 1'b1;
        send(0, 1, 1, 4'h0, 1);
        cycle();
        chk(ov[5] == 1'b0, "R10", ov, 0);
        cycle();
        chk(ov[5] == 1'b1, "R10", ov, 6'h20);
        drain();
        chk(got[1] == exp_dest[1], "R1", got[1], exp_dest[1]);

        // lockstep: child 2 blocked holds every copy
        do_reset();
        dn_cnt = 0; rdy_ovr = 6'b111011;
        send(5, 2, 0, 4'h0, 3);
        repeat (6) cycle();
        chk(dn_cnt == 0, "R5", dn_cnt, 0);
        rdy_ovr = '1;
        drain();
        chk(got[2] == exp_dest[2], "R3", got[2], exp_dest[2]);

        // turn at this node with a partial mask
        send(4, 3, 0, 4'b0101, 2);
        drain();
        chk(got[3] == 6'b010101, "R2", got[3], 6'b010101);

        // round-robin between two children at packet boundaries
        do_reset();
        nord = 0;
        send(0, 10, 1, 4'h0, 3); send(0, 11, 1, 4'h0, 3);
        send(1, 20, 1, 4'h0, 3); send(1, 21, 1, 4'h0, 3);
        drain();
        chk(ord[0] == 10, "R7", ord[0], 10);
        chk(ord[1] == 20, "R7", ord[1], 20);
        chk(ord[2] == 11, "R7", ord[2], 11);
        chk(ord[3] == 21, "R7", ord[3], 21);

        // random traffic, local endpoint enabled then disabled
        rnd_phase(60, 1'b1);
        rnd_phase(60, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule